// File: doc/BRIEF.md
# Serial Management Register Responder

This block is the device-side end of a two-wire serial management link. A host toggles a management clock and drives a data line with an output enable, both bit by bit in software. The block watches that clock from its own system clock and takes one bit on each rising edge. A host-driven bit counts as 1 only while its enable is also high. After a synchronisation run of 32 ones, the block decodes a 16-bit command header. It then either returns the contents of one of its 32 sixteen-bit registers or stores the 16 bits that follow.

The frame position comes from a down-counter. It is armed whenever the last 32 sampled bits were all ones. The whole header is decoded in the single step where the counter reaches the halfway point. There is no separate state for each field. The PHY address field is carried in the header, but every address is answered.

Top module: `mdio_reg_responder`

## Requirements
- R1: Each management-clock rising edge contributes one bit. The bit is 1 only when `md_host_data` and `md_host_en` are both 1; otherwise it is 0.
- R2: A frame can start only after 32 consecutive sampled ones. A run of 31 ones followed by a valid header has no effect. A run longer than 32 still arms the frame.
- R3: The 16 bits after the sync run are the header, taken first bit first. The layout is start[15:14], opcode[13:12], PHY address[11:7], register address[6:2] and turnaround[1:0]. The register address selects one of 32 registers.
- R4: A write is accepted when start = 01, opcode = 01 and turnaround = 10. The next 16 sampled bits, first bit as MSB, are stored into the addressed register on the 16th data edge.
- R5: A read is accepted when start = 01, opcode = 10 and turnaround bit 0 = 0. On each of the next 16 edges, `md_resp_data` presents the addressed register, MSB first.
- R6: Any other header writes no register and leaves `md_resp_data` unchanged for the rest of the frame.
- R7: After reset, register 2 holds 0x0022, register 3 holds 0x161A, every other register holds 0, and `md_resp_data` is 0.
- R8: `md_resp_data` changes only on a management-clock rising edge during a read. It holds its last driven value at all other times.
- R9: The PHY address field does not affect the response. A register written under one PHY address reads back under any other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc_in | input | 1 | Host management clock, asynchronous to clk |
| md_host_data | input | 1 | Data bit driven by the host |
| md_host_en | input | 1 | Host output enable for the data bit |
| md_resp_data | output | 1 | Data bit returned to the host |

## Verification
Several actions can land on the same management-clock edge. The last bit of a read is driven out on the edge that also returns the engine to idle. The commit of a write happens on the edge that ends the frame. The bench provokes both by sending a read and then a write back to back, separated only by the minimum 32-one sync run. A reference model, updated on every rising edge, is compared with `md_resp_data` before each following edge. The register contents are then read back to confirm that the frame after the coinciding edge was decoded and stored.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;

  // header field positions within the 16 bits following the sync run
  localparam int HDR_W    = 16;
  localparam int START_HI = 15;
  localparam int OPC_HI   = 13;
  localparam int REG_HI   = 6;
  localparam int REG_LO   = 2;
  localparam int TA_HI    = 1;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OPC_WRITE  = 2'b01;
  localparam logic [1:0] OPC_READ   = 2'b10;
  localparam logic [1:0] TA_WRITE   = 2'b10;

  function automatic logic [15:0] reset_word(int idx);
    case (idx)
      2:       return 16'h0022;
      3:       return 16'h161A;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc_in,
  input  logic data_in,
  input  logic en_in,
  output logic bit_stb,
  output logic bit_val
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] mdc_p, dat_p, en_p;
  logic          prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_p  <= '0;
      dat_p  <= '0;
      en_p   <= '0;
      prev_q <= 1'b0;
    end else begin
      mdc_p  <= {mdc_p[LAST-1:0], mdc_in};
      dat_p  <= {dat_p[LAST-1:0], data_in};
      en_p   <= {en_p[LAST-1:0], en_in};
      prev_q <= mdc_p[LAST];
    end
  end

  assign bit_stb = mdc_p[LAST] & ~prev_q;
  assign bit_val = dat_p[LAST] & en_p[LAST];

  // R1
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_resp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(reset_word(i));
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

  // R4
  store_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(addr)] == $past(wdata));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_resp_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int AW      = 5,
  parameter int FRAME_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic [DATA_W-1:0] rd_data,
  output logic [AW-1:0]     reg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              resp_bit
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]   cnt_q, cnt_t, cnt_n;
  logic               live_q, live_t, live_n;
  phase_e             ph_q, ph_n;
  logic [AW-1:0]      ra_q, ra_n;
  logic [DATA_W-1:0]  out_q, out_n;
  logic               resp_q, resp_n;
  logic               commit;

  always_comb begin
    sh_n   = {sh_q[FRAME_W-2:0], bit_val};
    live_t = live_q;
    cnt_t  = cnt_q;
    if (&sh_n) begin
      live_t = 1'b1;
      cnt_t  = CNT_W'(FRAME_W);
    end
    ph_n   = ph_q;
    ra_n   = ra_q;
    out_n  = out_q;
    resp_n = resp_q;
    commit = 1'b0;

    // header decode at the halfway count
    if (live_t && cnt_t == CNT_W'(HDR_W)) begin
      if (sh_n[START_HI -: 2] == START_CODE && sh_n[OPC_HI -: 2] == OPC_WRITE &&
          sh_n[TA_HI -: 2] == TA_WRITE)
        ph_n = PH_WRITE;
      else if (sh_n[START_HI -: 2] == START_CODE && sh_n[OPC_HI -: 2] == OPC_READ &&
               !sh_n[0])
        ph_n = PH_READ;
      else
        ph_n = PH_IDLE;
      if (ph_n != PH_IDLE) ra_n = AW'(sh_n[REG_HI:REG_LO]);
      if (ph_n == PH_READ) out_n = rd_data;
    end

    // data phase shift-out
    if ((!live_t || cnt_t < CNT_W'(HDR_W)) && ph_n == PH_READ) begin
      resp_n = out_n[DATA_W-1];
      out_n  = {out_n[DATA_W-2:0], 1'b0};
    end

    // end of frame
    if (live_t && cnt_t == '0 && ph_n != PH_IDLE) begin
      commit = (ph_n == PH_WRITE);
      ph_n   = PH_IDLE;
    end

    live_n = live_t;
    cnt_n  = cnt_t;
    if (live_t) begin
      if (cnt_t == '0) live_n = 1'b0;
      else             cnt_n  = cnt_t - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      live_q <= 1'b0;
      ph_q   <= PH_IDLE;
      ra_q   <= '0;
      out_q  <= '0;
      resp_q <= 1'b0;
    end else if (bit_stb) begin
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      live_q <= live_n;
      ph_q   <= ph_n;
      ra_q   <= ra_n;
      out_q  <= out_n;
      resp_q <= resp_n;
    end
  end

  assign reg_addr = ra_n;
  assign wr_en    = bit_stb & commit;
  assign wr_data  = sh_n[DATA_W-1:0];
  assign resp_bit = resp_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(FRAME_W));

  // R5
  resp_only_read_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(resp_q) |-> $past(ph_q) == PH_READ);

  // R8
  resp_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(resp_q) |-> $past(bit_stb));

endmodule

// File: rtl/mdio_reg_responder.sv
module mdio_reg_responder #(
  parameter int DATA_W      = 16,
  parameter int REG_COUNT   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc_in,
  input  logic md_host_data,
  input  logic md_host_en,
  output logic md_resp_data
);
  localparam int AW = $clog2(REG_COUNT);

  logic              bit_stb, bit_val, wr_en;
  logic [AW-1:0]     reg_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  mdio_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .mdc_in(mdc_in), .data_in(md_host_data),
    .en_in(md_host_en), .bit_stb(bit_stb), .bit_val(bit_val)
  );

  mdio_frame_engine #(.DATA_W(DATA_W), .AW(AW)) engine_i (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
    .rd_data(rd_data), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .resp_bit(md_resp_data)
  );

  mdio_reg_bank #(.DATA_W(DATA_W), .DEPTH(REG_COUNT), .AW(AW)) bank_i (
    .clk(clk), .rst(rst), .we(wr_en), .addr(reg_addr),
    .wdata(wr_data), .rdata(rd_data)
  );

endmodule

// File: tb/mdio_reg_responder_tb_top.sv
module mdio_reg_responder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_CLKS  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mdc = 1'b0, hd = 1'b0, he = 1'b0;
  logic resp;

  int compared = 0, mism = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit [31:0] m_sh = '0;
  int        m_cnt = 0;
  int        m_st = 0;      // 0 idle, 1 read, 2 write
  int        m_ra = 0;
  bit [15:0] m_out = '0;
  bit        m_resp = 1'b0;
  bit [15:0] m_regs [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_reg_responder dut_i (
    .clk(clk), .rst(rst), .mdc_in(mdc), .md_host_data(hd),
    .md_host_en(he), .md_resp_data(resp)
  );

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    compared++;
    if (got !== exp) begin
      mism++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_edge(bit b);
    bit [15:0] h;
    m_sh = {m_sh[30:0], b};
    if (m_sh == 32'hFFFF_FFFF) m_cnt = 32;
    if (m_cnt == 16) begin
      h = m_sh[15:0];
      if (h[15:14] == 2'b01 && h[13:12] == 2'b01 && h[1:0] == 2'b10) m_st = 2;
      else if (h[15:14] == 2'b01 && h[13:12] == 2'b10 && !h[0]) m_st = 1;
      else m_st = 0;
      if (m_st != 0) m_ra = int'(h[6:2]);
      if (m_st == 1) m_out = m_regs[m_ra];
    end
    if (m_cnt < 16 && m_st == 1) begin
      m_resp = m_out[15];
      m_out  = m_out << 1;
    end
    if (m_cnt == 0 && m_st != 0) begin
      if (m_st == 2) m_regs[m_ra] = m_sh[15:0];
      m_st = 0;
    end
    if (m_cnt > -4) m_cnt--;
  endtask

  // one management-clock period; returns the response after the rising edge
  task automatic mdc_bit(bit d, bit en, output bit seen);
    @(negedge clk);
    mdc = 1'b0; hd = d; he = en;
    repeat (HALF_CLKS) @(negedge clk);
    check("R8 per-edge model", {15'b0, resp}, {15'b0, m_resp});
    mdc = 1'b1;
    model_edge(d & en);
    repeat (HALF_CLKS) @(negedge clk);
    seen = resp;
  endtask

  task automatic send(bit [31:0] v, int n, bit en);
    bit s;
    for (int i = n - 1; i >= 0; i--) mdc_bit(v[i], en, s);
  endtask

  task automatic sync_run(int n);
    bit s;
    for (int i = 0; i < n; i++) mdc_bit(1'b1, 1'b1, s);
  endtask

  task automatic wr_frame(bit [4:0] phy, bit [4:0] ra, bit [15:0] val,
                          bit [1:0] opc = 2'b01, bit [1:0] ta = 2'b10,
                          bit data_en = 1'b1, int pre = 32);
    sync_run(pre);
    send({16'b0, 2'b01, opc, phy, ra, ta}, 16, 1'b1);
    send({16'b0, val}, 16, data_en);
  endtask

  task automatic rd_frame(bit [4:0] phy, bit [4:0] ra, output bit [15:0] got);
    bit s;
    sync_run(32);
    send({16'b0, 2'b01, 2'b10, phy, ra}, 14, 1'b1);
    mdc_bit(1'b1, 1'b0, s);
    mdc_bit(1'b0, 1'b0, s);
    for (int i = 15; i >= 0; i--) begin
      mdc_bit(1'b1, 1'b0, s);
      got[i] = s;
    end
  endtask

  task automatic idle_bits(int n);
    bit s;
    for (int i = 0; i < n; i++) mdc_bit(1'b0, 1'b0, s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mism++;
    compared++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit [15:0] v;
    bit        hold;
    for (int i = 0; i < 32; i++) m_regs[i] = 16'h0000;
    m_regs[2] = 16'h0022;
    m_regs[3] = 16'h161A;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 reset output", {15'b0, resp}, 16'h0000);

    rd_frame(5'd1, 5'd2, v);  check("R7 reg2 default", v, 16'h0022);
    rd_frame(5'd0, 5'd3, v);  check("R7 reg3 default", v, 16'h161A);
    rd_frame(5'd9, 5'd7, v);  check("R7 reg7 default", v, 16'h0000);

    wr_frame(5'd3, 5'd5, 16'hA5C3);
    rd_frame(5'd17, 5'd5, v); check("R4 R9 write/readback other phy", v, 16'hA5C3);

    wr_frame(5'd0, 5'd31, 16'hFFFF);
    rd_frame(5'd0, 5'd31, v); check("R4 reg31 all ones", v, 16'hFFFF);

    hold = resp;
    wr_frame(5'd3, 5'd5, 16'h1234, 2'b11);
    check("R6 bad opcode output held", {15'b0, resp}, {15'b0, hold});
    wr_frame(5'd3, 5'd5, 16'h4321, 2'b01, 2'b00);
    check("R6 bad turnaround output held", {15'b0, resp}, {15'b0, hold});
    rd_frame(5'd3, 5'd5, v);  check("R6 reg unchanged", v, 16'hA5C3);

    idle_bits(4);
    wr_frame(5'd3, 5'd5, 16'h0F0F, 2'b01, 2'b10, 1'b1, 31);
    idle_bits(4);
    rd_frame(5'd3, 5'd5, v);  check("R2 short sync ignored", v, 16'hA5C3);
    wr_frame(5'd3, 5'd6, 16'h3C3C, 2'b01, 2'b10, 1'b1, 40);
    rd_frame(5'd3, 5'd6, v);  check("R2 long sync accepted", v, 16'h3C3C);

    wr_frame(5'd2, 5'd9, 16'h5A5A);
    wr_frame(5'd2, 5'd9, 16'hFFFF, 2'b01, 2'b10, 1'b0);
    rd_frame(5'd2, 5'd9, v);  check("R1 enable low gives zeros", v, 16'h0000);

    wr_frame(5'd4, 5'd21, 16'h1357);
    rd_frame(5'd4, 5'd10, v); check("R3 mirrored address untouched", v, 16'h0000);
    rd_frame(5'd4, 5'd21, v); check("R3 address field decode", v, 16'h1357);

    wr_frame(5'd1, 5'd2, 16'h0BEE);
    rd_frame(5'd1, 5'd2, v);  check("R4 overwrite reg2", v, 16'h0BEE);

    // back-to-back: read end and next frame with minimal sync run
    rd_frame(5'd0, 5'd5, v);  check("R5 back-to-back read", v, 16'hA5C3);
    wr_frame(5'd0, 5'd12, 16'h8001);
    rd_frame(5'd0, 5'd12, v); check("R5 read after write", v, 16'h8001);

    repeat (30) @(negedge clk);
    check("R8 output holds last bit", {15'b0, resp}, 16'h0001);
    idle_bits(6);
    check("R8 idle edges keep output", {15'b0, resp}, 16'h0001);

    finish_run();
  end

endmodule